// File: doc/BRIEF.md
# Display Mode Switch Bank

This block is a small bus slave that keeps four display-mode flags for a video generator: text, mixed, alternate page and high resolution. Each flag owns a pair of addresses in the I/O page. Touching the odd address of a pair sets the flag and touching the even address clears it. The bus cycle itself is the command, so the direction of the access and any data on the bus are irrelevant.

A second group of addresses lets the processor read the flags back. A read there returns one flag on data bit 7, with the lower seven bits zero, and raises a read-data enable so the system data multiplexer can select this block. Every other address is ignored. The four flags leave the block as plain level outputs.

Top module: `disp_mode_flags`

## Requirements
- R1: An access to 0xC051 sets `text_on`; an access to 0xC050 clears it.
- R2: An access to 0xC053 sets `mixed_on`; an access to 0xC052 clears it.
- R3: An access to 0xC055 sets `page_alt`; an access to 0xC054 clears it.
- R4: An access to 0xC057 sets `hires_on`; an access to 0xC056 clears it.
- R5: Read accesses (`bus_rw`=1) and write accesses (`bus_rw`=0) to the addresses in R1 to R4 have the same effect.
- R6: A read of 0xC01A, 0xC01B, 0xC01C or 0xC01D returns the text, mixed, alternate-page or high-resolution flag respectively on `rd_data` bit 7, with bits 6..0 zero.
- R7: `rd_oe` is 1 only while `bus_en` is 1 with a read of one of the R6 addresses; otherwise `rd_oe` is 0 and `rd_data` is 0x00.
- R8: While `rst_n` is 0 the flags become text on, mixed, alternate page and high resolution off.
- R9: An access to any address outside 0xC050 to 0xC057, including writes to the R6 addresses, leaves all four flags unchanged.
- R10: A flag changes at the clock edge that ends the access; during the access cycle the old value is still shown, and a status read in the next cycle returns the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Bus access valid this cycle |
| bus_rw | input | 1 | 1 = read, 0 = write |
| bus_addr | input | 16 | Access address |
| rd_data | output | 8 | Status read data |
| rd_oe | output | 1 | Status read data valid |
| text_on | output | 1 | Text mode flag |
| mixed_on | output | 1 | Mixed mode flag |
| page_alt | output | 1 | Alternate display page flag |
| hires_on | output | 1 | High-resolution mode flag |

## Verification
The flag update caused by a switch access and the status read-back of that same flag meet at one clock edge when the two accesses are issued back to back. The bench provokes this by following every switch access, in both read and write form and from all sixteen starting flag states, immediately with the four status reads. It judges the access cycle itself against the old state and the next cycle against the state computed from the address bits.

// File: rtl/disp_mode_flags.sv
module disp_mode_flags #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_rw,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_oe,
  output logic              text_on,
  output logic              mixed_on,
  output logic              page_alt,
  output logic              hires_on
);
  localparam logic [ADDR_W-1:0] SW_BASE = ADDR_W'(16'hC050);
  localparam logic [ADDR_W-1:0] ST_BASE = ADDR_W'(16'hC01A);

  logic [3:0] flg;
  logic       sw_hit;
  logic       st_hit;
  logic [1:0] st_sel;

  assign sw_hit = bus_en && (bus_addr[ADDR_W-1:3] == SW_BASE[ADDR_W-1:3]);

  always_ff @(posedge clk) begin
    if (!rst_n)      flg <= 4'b0001;
    else if (sw_hit) flg[bus_addr[2:1]] <= bus_addr[0];
  end

  always_comb begin
    st_hit = 1'b0;
    st_sel = 2'd0;
    for (int i = 0; i < 4; i++) begin
      if (bus_addr == ST_BASE + ADDR_W'(i)) begin
        st_hit = bus_en && bus_rw;
        st_sel = 2'(i);
      end
    end
  end

  assign rd_oe   = st_hit;
  assign rd_data = st_hit ? {flg[st_sel], {(DATA_W-1){1'b0}}} : '0;

  assign text_on  = flg[0];
  assign mixed_on = flg[1];
  assign page_alt = flg[2];
  assign hires_on = flg[3];

  assert_text_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_addr == ADDR_W'(16'hC051)) |=> text_on);
  assert_text_clr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_addr == ADDR_W'(16'hC050)) |=> !text_on);
  assert_mixed_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_addr == ADDR_W'(16'hC053)) |=> mixed_on);
  assert_page_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_addr == ADDR_W'(16'hC055)) |=> page_alt);
  assert_hires_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_addr == ADDR_W'(16'hC056)) |=> !hires_on);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_en && bus_addr[ADDR_W-1:3] == SW_BASE[ADDR_W-1:3])
      |=> $stable({text_on, mixed_on, page_alt, hires_on}));
  assert_oe_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_oe |-> (bus_en && bus_rw && rd_data[DATA_W-2:0] == '0));
  assert_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_oe |-> (rd_data == '0));
endmodule

// File: tb/sim_disp_mode_flags.sv
`timescale 1ns/1ps
module sim_disp_mode_flags;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_en = 1'b0;
  logic bus_rw = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0] rd_data;
  logic rd_oe, text_on, mixed_on, page_alt, hires_on;
  int nrun = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  disp_mode_flags u0 (.clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_rw(bus_rw),
    .bus_addr(bus_addr), .rd_data(rd_data), .rd_oe(rd_oe), .text_on(text_on),
    .mixed_on(mixed_on), .page_alt(page_alt), .hires_on(hires_on));

  function automatic logic [3:0] flags();
    return {hires_on, page_alt, mixed_on, text_on};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nrun++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic [15:0] a, input bit rw,
                     output logic [7:0] rd, output logic oe, output logic [3:0] pre);
    @(negedge clk);
    bus_en = 1'b1; bus_addr = a; bus_rw = rw;
    #1;
    rd = rd_data; oe = rd_oe; pre = flags();
    @(posedge clk);
    #1;
    bus_en = 1'b0; bus_addr = '0; bus_rw = 1'b0;
  endtask

  task automatic load(input logic [3:0] s);
    logic [7:0] rd; logic oe; logic [3:0] pre;
    for (int i = 0; i < 4; i++) acc(16'hC050 + 16'(2*i) + 16'(s[i]), 1'b0, rd, oe, pre);
  endtask

  initial begin
    string ftag[4] = '{"R1", "R2", "R3", "R4"};
    logic [15:0] other[10] = '{16'hC04F, 16'hC058, 16'hC05F, 16'hC019, 16'hC01E,
                               16'hC150, 16'hD051, 16'h4051, 16'hC01A, 16'hC01D};
    logic [7:0] rd; logic oe; logic [3:0] pre; logic [3:0] exp;
    repeat (3) @(posedge clk);
    #1;
    chk("R8 reset flags", 32'(flags()), 32'h1);
    chk("R8 reset oe", 32'(rd_oe), 32'h0);
    @(negedge clk); rst_n = 1'b1;
    for (int j = 0; j < 4; j++) begin
      acc(16'hC01A + 16'(j), 1'b1, rd, oe, pre);
      chk("R8/R6 reset status", 32'(rd), (j == 0) ? 32'h80 : 32'h0);
    end
    for (int s = 0; s < 16; s++)
      for (int k = 0; k < 8; k++)
        for (int rw = 0; rw < 2; rw++) begin
          load(4'(s));
          acc(16'hC050 + 16'(k), rw[0], rd, oe, pre);
          chk("R10 old value in access cycle", 32'(pre), 32'(s));
          chk("R7 no oe on switch access", 32'(oe), 32'h0);
          exp = 4'(s);
          exp[k >> 1] = k[0];
          chk($sformatf("%s/R5 flags k=%0d rw=%0d s=%0d", ftag[k >> 1], k, rw, s),
              32'(flags()), 32'(exp));
          for (int j = 0; j < 4; j++) begin
            acc(16'hC01A + 16'(j), 1'b1, rd, oe, pre);
            chk($sformatf("R6/R10 status j=%0d", j), 32'(rd), 32'(exp[j]) << 7);
            chk("R7 oe on status read", 32'(oe), 32'h1);
          end
        end
    for (int p = 0; p < 2; p++) begin
      exp = p[0] ? 4'b0101 : 4'b1010;
      load(exp);
      for (int i = 0; i < 10; i++)
        for (int rw = 0; rw < 2; rw++) begin
          acc(other[i], rw[0], rd, oe, pre);
          chk($sformatf("R9 hold addr=%h rw=%0d", other[i], rw), 32'(flags()), 32'(exp));
          if (!(rw == 1 && i >= 8)) begin
            chk("R7 oe off", 32'(oe), 32'h0);
            chk("R7 data off", 32'(rd), 32'h0);
          end
        end
    end
    load(4'b1110);
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #1;
    chk("R8 reset after use", 32'(flags()), 32'h1);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      nrun++; nfail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", nrun, nfail);
      $finish;
    end
  end
endmodule